// File: doc/BRIEF.md
# Serial Bus Packet Responder

This block listens on a slow synchronous serial bus that has one bus clock, one shared data line and an active-high chip enable. A much faster system clock oversamples all three lines. Bits are taken in on rising bus-clock edges while the chip enable is high. The packet ends when the chip enable falls, and its bit count then decides how it is read. A 16-bit packet is a data word. A packet whose length equals the command width is a command code.

A decoder state machine reads sequences of commands. It turns a close followed by a reset into a dot-key event. It turns a reset followed by something else into an all-clear event. On a wait command it answers with a short reply, which it drives on falling bus-clock edges. In the data phase it separates header words from payload words, and after a header it predicts the length of the next packet. Payload words go into a small buffer, which the system reads through an index port.

Top module: `pkt_responder`

## Requirements
- R1: After reset, `busDataOe`, `evtValid`, `overflow`, `wordCount`, `expLen` and `hdrCount` are all zero.
- R2: While `busCe` is high, each rising `busClk` edge shifts in one bit of `busDataIn`, most significant bit first. A falling `busCe` closes the packet. In the data phase, 16-bit payload words are stored in arrival order and can be read at `rdWord` by index `rdIdx`.
- R3: A CLOSE command (default code 8'hC5) followed directly by a RESET command (default 8'hA3) produces a single-cycle `evtValid` with `evtCode` 1 (dot).
- R4: A RESET followed by any packet other than CLOSE or WAIT produces a single-cycle event with code 2 (all-clear). A RESET followed by CLOSE produces no event and arms the dot detection.
- R5: After an UNKNOWN-A command (default 8'h5C), the next packet is consumed without being decoded.
- R6: A WAIT command (default 8'h96) clears the word count and the overflow flag. It also drives a one-bit reply of value 0 onto the data line, present within a few system cycles of the chip enable falling. The reply is held until the next falling bus-clock edge and then released.
- R7: In the data phase, a 16-bit word with `word & 16'hFFF0 == 16'hFFF0` is a header. A header increments `hdrCount`, is not stored, and sets `expLen` to 6. The next 6-bit packet is consumed, and the data phase resumes.
- R8: The word buffer holds 8 entries. `wordCount` never exceeds 8. A further payload word sets `overflow` and overwrites nothing.
- R9: `busDataOe` is high only while a reply is pending.
- R10: A 16-bit packet that arrives outside the data phase is ignored, and `wordCount` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busClk | input | 1 | Bus clock (asynchronous) |
| busCe | input | 1 | Bus chip enable, active high |
| busDataIn | input | 1 | Data line as received |
| busDataOut | output | 1 | Reply bit value |
| busDataOe | output | 1 | Drive enable for the data line |
| evtValid | output | 1 | Single-cycle key event strobe |
| evtCode | output | 3 | Event code: 1 dot, 2 all-clear |
| wordCount | output | 4 | Stored payload words |
| overflow | output | 1 | A payload word was dropped because the buffer was full |
| rdIdx | input | 3 | Buffer read index |
| rdWord | output | 16 | Buffer word at rdIdx |
| expLen | output | 5 | Predicted length of the next packet (0 = none) |
| hdrCount | output | 5 | Header words seen |

## Verification
A packet takes effect about four system cycles after the chip enable falls: two synchronizer flops, one edge-detect register and one result register. The bench therefore waits eight system cycles after each packet before it samples any count, flag or buffer word. The reply is checked eight cycles after the wait packet closes. It is checked again while the bus clock is high and six cycles after the bus clock falls, which is when the release must be visible. Events last only one cycle, so a monitor counts them on every falling system-clock edge, and the checks compare those running totals against the expected sums.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef struct packed {
    logic loadTx;
    logic storeWord;
    logic clearWords;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_POSS_DOT, ST_POSS_AC, ST_RX_UNKA,
    ST_RX_WAIT, ST_WAIT_DATA, ST_WAIT_2
  } state_t;

  localparam logic [2:0] EVT_DOT = 3'd1;
  localparam logic [2:0] EVT_AC  = 3'd2;
endpackage

// File: rtl/pkt_datapath.sv
module pkt_datapath
  import pkt_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int CNT_W      = 5,
  parameter int DEPTH      = 8,
  parameter int REPLY_BITS = 1,
  parameter logic [7:0] REPLY_VAL = 8'h00,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              busCe,
  input  logic              busDataIn,
  input  ctrlStrobe_t       strobe,
  output logic              pktDone,
  output logic [CNT_W-1:0]  pktBits,
  output logic [WORD_W-1:0] pktWord,
  output logic              txDone,
  output logic              dataOut,
  output logic              dataOe,
  output logic [FILL_W-1:0] fill,
  output logic              ovf,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdWord
);
  logic [1:0] clkSync, ceSync, datSync;
  logic clkPrev, cePrev;
  logic clkRise, clkFall, ceFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSync <= '0; ceSync <= '0; datSync <= '0;
      clkPrev <= 1'b0; cePrev <= 1'b0;
    end else begin
      clkSync <= {clkSync[0], busClk};
      ceSync  <= {ceSync[0], busCe};
      datSync <= {datSync[0], busDataIn};
      clkPrev <= clkSync[1];
      cePrev  <= ceSync[1];
    end
  end

  assign clkRise = clkSync[1] & ~clkPrev;
  assign clkFall = ~clkSync[1] & clkPrev;
  assign ceFall  = ~ceSync[1] & cePrev;

  // receive shifter
  logic [WORD_W-1:0] rxShift;
  logic [CNT_W-1:0]  bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      bitCnt  <= '0;
    end else if (ceFall) begin
      bitCnt <= '0;
    end else if (clkRise && ceSync[1]) begin
      rxShift <= {rxShift[WORD_W-2:0], datSync[1]};
      if (bitCnt != '1) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign pktDone = ceFall;
  assign pktBits = bitCnt;
  assign pktWord = rxShift;

  // transmit shifter: first bit preloaded, advanced on falling bus edges
  logic [REPLY_BITS-1:0] txReg;
  logic [CNT_W-1:0]      txLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0; txLeft <= '0; dataOe <= 1'b0; txDone <= 1'b0;
    end else begin
      txDone <= 1'b0;
      if (strobe.loadTx) begin
        txReg  <= REPLY_VAL[REPLY_BITS-1:0];
        txLeft <= CNT_W'(REPLY_BITS);
        dataOe <= 1'b1;
      end else if (clkFall && dataOe) begin
        if (txLeft == CNT_W'(1)) begin
          dataOe <= 1'b0;
          txLeft <= '0;
          txDone <= 1'b1;
        end else begin
          txReg  <= txReg << 1;
          txLeft <= txLeft - 1'b1;
        end
      end
    end
  end

  assign dataOut = dataOe & txReg[REPLY_BITS-1];

  // payload word store
  logic [WORD_W-1:0] mem [DEPTH];
  logic full;
  assign full = (fill == FILL_W'(DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fill <= '0;
      ovf  <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (strobe.clearWords) begin
      fill <= '0;
      ovf  <= 1'b0;
    end else if (strobe.storeWord) begin
      if (full) ovf <= 1'b1;
      else begin
        mem[fill[IDX_W-1:0]] <= pktWord;
        fill <= fill + 1'b1;
      end
    end
  end

  assign rdWord = mem[rdIdx];

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    fill <= FILL_W'(DEPTH));
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.storeWord && !strobe.clearWords && full) |=> (full && ovf));
  assert_reply_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTx |=> dataOe);
  assert_release_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dataOe) |-> $past(clkFall));
  assert_oe_pending_R9: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (txLeft != '0));
endmodule

// File: rtl/pkt_control.sv
module pkt_control
  import pkt_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int CNT_W    = 5,
  parameter int HCNT_W   = 5,
  parameter int CMD_W    = 8,
  parameter logic [7:0] CMD_CLOSE = 8'hC5,
  parameter logic [7:0] CMD_RESET = 8'hA3,
  parameter logic [7:0] CMD_UNKA  = 8'h5C,
  parameter logic [7:0] CMD_WAIT  = 8'h96,
  parameter logic [15:0] HDR_MASK = 16'hFFF0,
  parameter int NEXT_LEN = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktDone,
  input  logic [CNT_W-1:0]  pktBits,
  input  logic [WORD_W-1:0] pktWord,
  input  logic              txDone,
  output ctrlStrobe_t       strobe,
  output logic              evtValid,
  output logic [2:0]        evtCode,
  output logic [CNT_W-1:0]  expLen,
  output logic [HCNT_W-1:0] hdrCount
);
  state_t state, stateNx, idleNext;
  logic isWord, isCmd, isClose, isReset, isUnka, isWait, isHeader;
  logic [CMD_W-1:0] cmd;
  logic evtNx, hdrInc;
  logic [2:0] codeNx;
  logic [CNT_W-1:0] lenNx;

  assign isWord   = (pktBits == CNT_W'(WORD_W));
  assign isCmd    = (pktBits == CNT_W'(CMD_W));
  assign cmd      = pktWord[CMD_W-1:0];
  assign isClose  = isCmd && (cmd == CMD_CLOSE[CMD_W-1:0]);
  assign isReset  = isCmd && (cmd == CMD_RESET[CMD_W-1:0]);
  assign isUnka   = isCmd && (cmd == CMD_UNKA[CMD_W-1:0]);
  assign isWait   = isCmd && (cmd == CMD_WAIT[CMD_W-1:0]);
  assign isHeader = ((pktWord & HDR_MASK[WORD_W-1:0]) == HDR_MASK[WORD_W-1:0]);

  always_comb begin
    if (isClose)      idleNext = ST_POSS_DOT;
    else if (isReset) idleNext = ST_POSS_AC;
    else if (isUnka)  idleNext = ST_RX_UNKA;
    else              idleNext = ST_IDLE;
  end

  always_comb begin
    stateNx = state;
    strobe  = '0;
    evtNx   = 1'b0;
    codeNx  = 3'd0;
    hdrInc  = 1'b0;
    lenNx   = expLen;
    if (txDone && state == ST_RX_WAIT) stateNx = ST_WAIT_DATA;
    if (pktDone) begin
      if (isWait) begin
        stateNx = ST_RX_WAIT;
        strobe.loadTx = 1'b1;
        strobe.clearWords = 1'b1;
        lenNx = '0;
      end else begin
        case (state)
          ST_POSS_DOT: begin
            if (isReset) begin
              evtNx = 1'b1; codeNx = EVT_DOT; stateNx = ST_IDLE;
            end else stateNx = idleNext;
          end
          ST_POSS_AC: begin
            if (isClose) stateNx = ST_POSS_DOT;
            else begin
              evtNx = 1'b1; codeNx = EVT_AC; stateNx = ST_IDLE;
            end
          end
          ST_RX_UNKA: stateNx = ST_IDLE;
          ST_RX_WAIT: stateNx = ST_RX_WAIT;
          ST_WAIT_DATA: begin
            if (isWord) begin
              if (isHeader) begin
                hdrInc = 1'b1; lenNx = CNT_W'(NEXT_LEN); stateNx = ST_WAIT_2;
              end else strobe.storeWord = 1'b1;
            end else stateNx = idleNext;
          end
          ST_WAIT_2: begin
            if (pktBits == expLen) stateNx = ST_WAIT_DATA;
            else stateNx = idleNext;
          end
          default: stateNx = idleNext;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; evtValid <= 1'b0; evtCode <= 3'd0;
      expLen <= '0; hdrCount <= '0;
    end else begin
      state <= stateNx; evtValid <= evtNx; evtCode <= codeNx; expLen <= lenNx;
      if (hdrInc) hdrCount <= hdrCount + 1'b1;
    end
  end

  assert_evt_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |=> !evtValid);
  assert_evt_code_R4: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtCode == EVT_DOT || evtCode == EVT_AC));
  assert_hdr_len_R7: assert property (@(posedge clk) disable iff (!rstN)
    $changed(hdrCount) |-> (expLen == CNT_W'(NEXT_LEN) && state == ST_WAIT_2));
endmodule

// File: rtl/pkt_responder.sv
module pkt_responder
  import pkt_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5,
  parameter int HCNT_W = 5,
  parameter int DEPTH  = 8,
  parameter int CMD_W  = 8,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busClk,
  input  logic              busCe,
  input  logic              busDataIn,
  output logic              busDataOut,
  output logic              busDataOe,
  output logic              evtValid,
  output logic [2:0]        evtCode,
  output logic [FILL_W-1:0] wordCount,
  output logic              overflow,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [WORD_W-1:0] rdWord,
  output logic [CNT_W-1:0]  expLen,
  output logic [HCNT_W-1:0] hdrCount
);
  ctrlStrobe_t strobe;
  logic pktDone, txDone;
  logic [CNT_W-1:0] pktBits;
  logic [WORD_W-1:0] pktWord;

  pkt_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busCe(busCe), .busDataIn(busDataIn),
    .strobe(strobe), .pktDone(pktDone), .pktBits(pktBits), .pktWord(pktWord),
    .txDone(txDone), .dataOut(busDataOut), .dataOe(busDataOe),
    .fill(wordCount), .ovf(overflow), .rdIdx(rdIdx), .rdWord(rdWord));

  pkt_control #(.WORD_W(WORD_W), .CNT_W(CNT_W), .HCNT_W(HCNT_W), .CMD_W(CMD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .pktDone(pktDone), .pktBits(pktBits), .pktWord(pktWord),
    .txDone(txDone), .strobe(strobe), .evtValid(evtValid), .evtCode(evtCode),
    .expLen(expLen), .hdrCount(hdrCount));
endmodule

// File: tb/tb_pkt_responder.sv
module tb_pkt_responder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busClk = 1'b0, busCe = 1'b0, busDataIn = 1'b0;
  logic busDataOut, busDataOe, evtValid, overflow;
  logic [2:0] evtCode;
  logic [3:0] wordCount;
  logic [2:0] rdIdx = '0;
  logic [15:0] rdWord;
  logic [4:0] expLen, hdrCount;

  int tests = 0, fails = 0, dotCnt = 0, acCnt = 0, badCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pkt_responder dut (
    .clk(clk), .rstN(rstN), .busClk(busClk), .busCe(busCe), .busDataIn(busDataIn),
    .busDataOut(busDataOut), .busDataOe(busDataOe), .evtValid(evtValid),
    .evtCode(evtCode), .wordCount(wordCount), .overflow(overflow), .rdIdx(rdIdx),
    .rdWord(rdWord), .expLen(expLen), .hdrCount(hdrCount));

  always @(negedge clk) begin
    if (evtValid) begin
      if (evtCode == 3'd1) dotCnt++;
      else if (evtCode == 3'd2) acCnt++;
      else badCnt++;
    end
  end

  localparam logic [7:0] CLOSE = 8'hC5, RESET = 8'hA3, UNKA = 8'h5C, WAIT = 8'h96, OTHER = 8'h11;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sendPkt(input logic [15:0] val, input int n);
    @(negedge clk); busCe = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      busDataIn = val[i];
      repeat (3) @(negedge clk); busClk = 1'b1;
      repeat (5) @(negedge clk); busClk = 1'b0;
      repeat (2) @(negedge clk);
    end
    busCe = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic waitAndReply;
    sendPkt({8'h00, WAIT}, 8);
    chk("R6 oe after wait", int'(busDataOe), 1);
    chk("R6 reply bit", int'(busDataOut), 0);
    chk("R6 count cleared", int'(wordCount), 0);
    chk("R6 overflow cleared", int'(overflow), 0);
    busClk = 1'b1; repeat (6) @(negedge clk);
    chk("R6 held over rising edge", int'(busDataOe), 1);
    busClk = 1'b0; repeat (6) @(negedge clk);
    chk("R9 released after falling edge", int'(busDataOe), 0);
  endtask

  function automatic logic [15:0] payload(input int k);
    return 16'h1000 + 16'(k) * 16'h0111;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 oe", int'(busDataOe), 0);
    chk("R1 evt", int'(evtValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 count", int'(wordCount), 0);
    chk("R1 overflow", int'(overflow), 0);
    chk("R1 expLen", int'(expLen), 0);
    chk("R1 hdrCount", int'(hdrCount), 0);

    // R3 dot
    sendPkt({8'h0, CLOSE}, 8);
    sendPkt({8'h0, RESET}, 8);
    chk("R3 dot event", dotCnt, 1);
    chk("R3 no all-clear", acCnt, 0);

    // R4 all-clear, then reset-close-reset gives dot
    sendPkt({8'h0, RESET}, 8);
    sendPkt({8'h0, OTHER}, 8);
    chk("R4 all-clear", acCnt, 1);
    sendPkt({8'h0, RESET}, 8);
    sendPkt({8'h0, CLOSE}, 8);
    chk("R4 no event on reset-close", dotCnt + acCnt, 2);
    sendPkt({8'h0, RESET}, 8);
    chk("R4 close re-arms dot", dotCnt, 2);

    // R5 unknown-A swallows close
    sendPkt({8'h0, UNKA}, 8);
    sendPkt({8'h0, CLOSE}, 8);
    sendPkt({8'h0, RESET}, 8);
    chk("R5 no dot after swallowed close", dotCnt, 2);
    sendPkt({8'h0, OTHER}, 8);
    chk("R5 reset seen as all-clear", acCnt, 2);

    // R10 word outside data phase
    sendPkt(16'h1234, 16);
    chk("R10 word ignored", int'(wordCount), 0);

    // R6 reply, then R2/R8 fill sweep
    waitAndReply();
    for (int k = 0; k < 10; k++) begin
      sendPkt(payload(k), 16);
      chk("R8 count", int'(wordCount), (k + 1 > 8) ? 8 : k + 1);
      chk("R8 overflow", int'(overflow), (k >= 8) ? 1 : 0);
    end
    for (int i = 0; i < 8; i++) begin
      rdIdx = 3'(i); @(negedge clk);
      chk("R2 stored word", int'(rdWord), int'(payload(i)));
    end

    // R7 headers
    waitAndReply();
    sendPkt(16'h0ABC, 16);
    chk("R2 first after clear", int'(wordCount), 1);
    for (int n = 0; n < 16; n++) begin
      sendPkt(16'hFFF0 | 16'(n), 16);
      chk("R7 header count", int'(hdrCount), n + 1);
      chk("R7 expLen", int'(expLen), 6);
      chk("R7 header not stored", int'(wordCount), 1);
      sendPkt(16'h002A, 6);
    end
    sendPkt(16'hFFE0, 16);
    chk("R7 near-header stored", int'(wordCount), 2);
    rdIdx = 3'd1; @(negedge clk);
    chk("R7 word after header", int'(rdWord), 16'hFFE0);
    chk("R3 no bad event codes", badCnt, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule